// File: doc/BRIEF.md
# I2C Bus Watcher with Own-Address Recognition

This block sits beside a two-wire serial controller and observes the clock and data lines at all times, whether the local controller is driving the bus as a master or waiting as a slave. It cleans up both lines with a two-flop synchronizer followed by a three-sample majority vote. From the cleaned lines it finds START, repeated START and STOP conditions, and it keeps a bus-busy indication that follows them no matter which controller produced them.

After every START, including a repeated START, the block shifts in the first byte with the most significant bit first. Bits 7..1 of that byte form the address and bit 0 is the read/write bit. The address is compared with a programmable own address and with the all-zero general-call value. A hit raises a sticky flag and requests that the data line be held low for the ninth (acknowledge) clock. Recognition works even while the local controller is a master. A master that loses arbitration during an address byte can therefore find itself addressed by that same byte. Bytes after the address are left to other logic.

Top module: `i2c_addr_watch`

## Requirements
- R1: A falling edge of the filtered data line while the filtered clock line is high (START) sets `bus_busy` to 1.
- R2: A rising edge of the filtered data line while the filtered clock line is high (STOP) clears `bus_busy`, `addr_hit`, `gen_call` and `ack_pull` to 0.
- R3: After each START, the first 8 bits sampled on clock rising edges are taken MSB first. Bits 7..1 are the address and bit 0 appears on `rw_bit`, which keeps that value until the next address byte.
- R4: `addr_hit` becomes 1 after the eighth bit when the address equals `own_addr` and `match_en_n` is 0. While `match_en_n` is 1, no address sets it.
- R5: `gen_call` becomes 1 after the eighth bit when the address is all zeros and `match_en_n` is 0.
- R6: When the current address byte set `addr_hit` or `gen_call`, `ack_pull` rises on the clock falling edge after the eighth bit and holds through the high phase of the ninth clock. It falls on the ninth clock's falling edge. For any other byte it stays 0.
- R7: A repeated START (a START while `bus_busy` is 1) restarts address reception. The next byte is evaluated as an address and `bus_busy` stays 1 throughout.
- R8: `addr_hit` and `gen_call` stay set across later data bytes and are cleared only by STOP or by a one-cycle `flag_clr` pulse.
- R9: A data-line pulse lasting one `clk` cycle while the clock line is high is removed by the filter and produces neither START nor STOP.
- R10: Bits clocked after the ninth clock of the address byte change neither the flags nor `rw_bit`, and they never raise `ack_pull`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level (asynchronous) |
| sda_in | input | 1 | Bus data line level (asynchronous) |
| own_addr | input | ADDR_W | Address this controller answers to |
| match_en_n | input | 1 | 0 enables address recognition |
| flag_clr | input | 1 | One-cycle pulse that clears `addr_hit` and `gen_call` |
| bus_busy | output | 1 | 1 between START and STOP |
| addr_hit | output | 1 | Own address was received |
| gen_call | output | 1 | General-call address was received |
| rw_bit | output | 1 | Read/write bit of the last address byte |
| ack_pull | output | 1 | Request to hold the data line low for the acknowledge |

## Verification
The bench uses the default `ADDR_W` of 7 with an own address of 0x4A. At that width all 128 address values can be swept once with recognition enabled and once with it disabled, and the read/write bit alternates across the sweep. Each value is checked for the flags, the acknowledge request and `rw_bit` against arithmetic expectations. Directed sequences cover the points a sweep cannot reach: a repeated START, a data byte following a hit, the software clear while the bus is busy, and a one-cycle glitch on an idle bus.

// File: rtl/i2c_addr_watch.sv
module i2c_addr_watch #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              match_en_n,
  input  logic              flag_clr,
  output logic              bus_busy,
  output logic              addr_hit,
  output logic              gen_call,
  output logic              rw_bit,
  output logic              ack_pull
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CW     = $clog2(BYTE_W + 2);

  logic [1:0] scl_sy, sda_sy;
  logic [2:0] scl_win, sda_win;
  logic       scl_f, sda_f, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy  <= '1;  sda_sy  <= '1;
      scl_win <= '1;  sda_win <= '1;
      scl_f   <= 1'b1; sda_f  <= 1'b1;
      scl_q   <= 1'b1; sda_q  <= 1'b1;
    end else begin
      scl_sy  <= {scl_sy[0], scl_in};
      sda_sy  <= {sda_sy[0], sda_in};
      scl_win <= {scl_win[1:0], scl_sy[1]};
      sda_win <= {sda_win[1:0], sda_sy[1]};
      scl_f   <= (scl_win[0] & scl_win[1]) | (scl_win[0] & scl_win[2]) | (scl_win[1] & scl_win[2]);
      sda_f   <= (sda_win[0] & sda_win[1]) | (sda_win[0] & sda_win[2]) | (sda_win[1] & sda_win[2]);
      scl_q   <= scl_f;
      sda_q   <= sda_f;
    end
  end

  wire start_det = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  wire scl_rise  = scl_f & ~scl_q;
  wire scl_fall  = ~scl_f & scl_q;

  logic              rx_act, want_ack;
  logic [CW-1:0]     bit_cnt;
  logic [ADDR_W-1:0] sh;

  wire last_bit = rx_act & scl_rise & (bit_cnt == CW'(ADDR_W));
  wire own_eq   = ~match_en_n & (sh == own_addr);
  wire gc_eq    = ~match_en_n & (sh == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_busy <= 1'b0; rx_act <= 1'b0; want_ack <= 1'b0;
      ack_pull <= 1'b0; bit_cnt <= '0; sh <= '0; rw_bit <= 1'b0;
    end else if (start_det) begin
      bus_busy <= 1'b1; rx_act <= 1'b1; want_ack <= 1'b0;
      ack_pull <= 1'b0; bit_cnt <= '0;
    end else if (stop_det) begin
      bus_busy <= 1'b0; rx_act <= 1'b0; want_ack <= 1'b0;
      ack_pull <= 1'b0;
    end else if (rx_act) begin
      if (scl_rise) begin
        if (bit_cnt < CW'(ADDR_W)) sh <= {sh[ADDR_W-2:0], sda_f};
        if (last_bit) begin
          rw_bit   <= sda_f;
          want_ack <= own_eq | gc_eq;
        end
        bit_cnt <= bit_cnt + 1'b1;
      end else if (scl_fall) begin
        if (bit_cnt == CW'(BYTE_W) && want_ack) ack_pull <= 1'b1;
        if (bit_cnt == CW'(BYTE_W + 1)) begin
          ack_pull <= 1'b0;
          rx_act   <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_hit <= 1'b0;
      gen_call <= 1'b0;
    end else if (stop_det) begin
      addr_hit <= 1'b0;
      gen_call <= 1'b0;
    end else begin
      if (flag_clr) begin
        addr_hit <= 1'b0;
        gen_call <= 1'b0;
      end
      if (last_bit && own_eq) addr_hit <= 1'b1;
      if (last_bit && gc_eq)  gen_call <= 1'b1;
    end
  end

  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> bus_busy);
  assert_stop_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!bus_busy && !addr_hit && !gen_call && !ack_pull));
  assert_hit_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_hit) |-> !$past(match_en_n));
  assert_gc_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gen_call) |-> !$past(match_en_n));
  assert_ack_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_pull) |-> !$past(scl_f));
  assert_ack_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pull |-> bus_busy);
endmodule

// File: tb/i2c_addr_watch_tb_top.sv
module i2c_addr_watch_tb_top;
  localparam int P = 6;
  localparam logic [6:0] OWN = 7'h4A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic [6:0] own_addr = OWN;
  logic match_en_n = 1'b0, flag_clr = 1'b0;
  logic bus_busy, addr_hit, gen_call, rw_bit, ack_pull;
  logic sda_bus;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  assign sda_bus = sda_drv & ~ack_pull;

  always #4 clk = ~clk;

  i2c_addr_watch #(.ADDR_W(7)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_bus),
    .own_addr(own_addr), .match_en_n(match_en_n), .flag_clr(flag_clr),
    .bus_busy(bus_busy), .addr_hit(addr_hit), .gen_call(gen_call),
    .rw_bit(rw_bit), .ack_pull(ack_pull));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    sda_drv = 1'b1; wt(P); scl_drv = 1'b1; wt(P);
    sda_drv = 1'b0; wt(P); scl_drv = 1'b0; wt(P);
  endtask

  task automatic do_stop();
    sda_drv = 1'b0; wt(P); scl_drv = 1'b1; wt(P);
    sda_drv = 1'b1; wt(2*P);
  endtask

  task automatic send_bit(input logic b);
    sda_drv = b; wt(P); scl_drv = 1'b1; wt(2*P); scl_drv = 1'b0; wt(P);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ackd);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_drv = 1'b1; wt(P); scl_drv = 1'b1; wt(P);
    ackd = ack_pull & ~sda_bus;
    wt(P); scl_drv = 1'b0; wt(P);
  endtask

  initial begin
    logic ackd;
    wt(3); rst_n = 1'b1; wt(2);
    chk("R1 reset busy", bus_busy, 0);
    chk("R2 reset flags", {addr_hit, gen_call, ack_pull}, 0);

    // R9: single-cycle data glitch while clock high on idle bus
    sda_drv = 1'b0; wt(1); sda_drv = 1'b1; wt(12);
    chk("R9 glitch no start", bus_busy, 0);

    // Sweep with recognition enabled: R1 R3 R4 R5 R6 R2
    for (int a = 0; a < 128; a++) begin
      int r;
      r = (a >> 3) & 1;
      do_start();
      chk("R1 busy after start", bus_busy, 1);
      send_byte({a[6:0], r[0]}, ackd);
      chk("R4 own hit", addr_hit, (a == OWN) ? 1 : 0);
      chk("R5 general call", gen_call, (a == 0) ? 1 : 0);
      chk("R3 rw bit", rw_bit, r);
      chk("R6 ack request", ackd, (a == OWN || a == 0) ? 1 : 0);
      wt(P);
      chk("R6 ack released", ack_pull, 0);
      do_stop();
      chk("R2 stop busy", bus_busy, 0);
      chk("R2 stop flags", {addr_hit, gen_call}, 0);
    end

    // Sweep with recognition disabled: R4 R5 R6
    match_en_n = 1'b1;
    for (int a = 0; a < 128; a++) begin
      int r;
      r = a & 1;
      do_start();
      send_byte({a[6:0], r[0]}, ackd);
      chk("R4 disabled no hit", addr_hit, 0);
      chk("R5 disabled no gc", gen_call, 0);
      chk("R6 disabled no ack", ackd, 0);
      chk("R3 rw bit disabled", rw_bit, r);
      do_stop();
    end
    match_en_n = 1'b0;

    // R7: repeated START, first address misses, second hits
    do_start();
    send_byte({7'h11, 1'b0}, ackd);
    chk("R7 first byte no ack", ackd, 0);
    chk("R7 busy before restart", bus_busy, 1);
    do_start();
    chk("R7 busy after restart", bus_busy, 1);
    send_byte({OWN, 1'b1}, ackd);
    chk("R7 restart hit", addr_hit, 1);
    chk("R7 restart ack", ackd, 1);
    chk("R7 restart rw", rw_bit, 1);

    // R10: data byte after address ignored
    send_byte(8'h00, ackd);
    chk("R10 data no ack", ackd, 0);
    chk("R10 data no gc", gen_call, 0);
    chk("R10 rw kept", rw_bit, 1);
    chk("R8 hit held over data", addr_hit, 1);

    // R8: software clear while busy
    @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0; wt(1);
    chk("R8 clear strobe", addr_hit, 0);
    chk("R8 busy kept", bus_busy, 1);
    do_stop();
    chk("R2 final stop", bus_busy, 0);

    // Other own address values: R4
    for (int k = 0; k < 3; k++) begin
      logic [6:0] oa;
      oa = (k == 0) ? 7'h7F : (k == 1) ? 7'h01 : 7'h55;
      own_addr = oa;
      do_start();
      send_byte({oa, 1'b0}, ackd);
      chk("R4 alt own hit", addr_hit, 1);
      chk("R6 alt own ack", ackd, 1);
      do_stop();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule